// File: doc/BRIEF.md
# Trim Setting Commit and Recall Sequencer

This block keeps three byte-wide trim registers in step with a small nonvolatile store. The store is modelled as three bytes held in flops. At power-up, and again after a soft reset, the block runs a timed recall. During recall it holds busy high and shows the high-impedance code on every live output. When the recall window ends it loads all stored bytes into the live registers and raises `recall_done_o`.

The serial slave in front of this block passes on every completed register write as a one-cycle request. The request carries a channel index and a byte. The live register takes the byte at once, and the byte is armed for programming. Programming starts only when the slave later reports a bus stop. The commit then holds busy high for a fixed number of cycles, and the byte lands in the store at the end. While busy is high the slave ignores the bus and refuses to acknowledge. A host therefore learns that a commit has finished by polling for an acknowledge. A standby flag reports when the block is quiet.

Top module: `nvseq_top`

## Requirements
- R1: After a power-on reset and its recall, every live output equals the factory default byte 0x7F.
- R2: After `rst_ni` is released, `busy_o` stays high for exactly RECALL_CYCLES cycles. `recall_done_o` rises in the same cycle that busy falls.
- R3: While recall has not completed, each live output shows 0x80, with bit 7 set as the high-impedance code. `recall_done_o` is 0 during this time.
- R4: A request accepted while not busy, with a channel index of 0, 1 or 2, updates that live output on the next cycle. No commit starts until `stop_seen_i` is seen.
- R5: A stop that follows an accepted request holds `busy_o` high for exactly COMMIT_CYCLES cycles. After that the byte is in the store, so a later recall returns it.
- R6: A request that arrives while busy is dropped. The live output keeps its value, and a stop after busy falls starts no commit.
- R7: A request with channel index 3 is ignored. It changes no live output, does not clear standby and arms nothing.
- R8: `soft_rst_i` sets the live outputs to 0x80 and reruns the RECALL_CYCLES recall. It keeps the store, so committed bytes return and uncommitted writes are lost.
- R9: `rst_ni` low restores all three store bytes to 0x7F.
- R10: `standby_o` rises when recall ends, when a commit ends, and on a stop while nothing is armed. It falls when a request is accepted and stays low while busy.
- R11: When several requests are accepted before one stop, only the most recent byte is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset; reloads store defaults |
| soft_rst_i | input | 1 | Synchronous soft reset; keeps store |
| commit_req_i | input | 1 | One-cycle register write request from the slave |
| commit_ch_i | input | 2 | Channel index of the request |
| commit_data_i | input | 8 | Byte written |
| stop_seen_i | input | 1 | One-cycle bus stop indication |
| busy_o | output | 1 | Recall or commit running; slave must stay deaf |
| recall_done_o | output | 1 | Stored values are valid in the live registers |
| live0_o | output | 8 | Live register, channel 0 |
| live1_o | output | 8 | Live register, channel 1 |
| live2_o | output | 8 | Live register, channel 2 |
| standby_o | output | 1 | Block quiet |

## Verification
The bench counts busy cycles exactly for both windows, at power-up and after a soft reset. A timer that is off by one, or that is not cleared between windows, shows up as a wrong count. A request made during a commit is checked in two ways: the live value must hold, and a later stop must not start a second commit. A design that latched the request while busy would fail one of these. Soft reset is followed by a recall that must return the committed bytes and drop the ones that were never committed. This catches a store that is cleared on soft reset and a store written before the stop. Two writes before one stop check that only the latest byte is committed, and a channel 3 request checks that an out-of-range index is dropped.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  localparam int NUM_CH = 3;
  localparam int DW = 8;
  localparam int CH_W = 2;
  localparam logic [DW-1:0] DEF_VAL = 8'h7F;
  localparam logic [DW-1:0] HIZ_VAL = 8'h80;

  typedef enum logic [1:0] {
    ST_RECALL = 2'd0,
    ST_IDLE   = 2'd1,
    ST_COMMIT = 2'd2
  } seq_state_e;

  typedef logic [NUM_CH-1:0][DW-1:0] bank_t;
endpackage

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || done_o) cnt_q <= '0;
    else if (en_i)           cnt_q <= cnt_q + 1'b1;
  end

  // R2/R5: the count never runs past the selected window
  p_cnt_in_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < limit_i));
endmodule

// File: rtl/nvseq_store.sv
module nvseq_store
  import nvseq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic [DW-1:0]   data_i,
  output bank_t           bank_o
);
  bank_t mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CH; i++) mem_q[i] <= DEF_VAL;
    end else if (we_i) begin
      mem_q[ch_i] <= data_i;
    end
  end

  assign bank_o = mem_q;

  // R5/R8: the store changes only through the commit write port
  p_store_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/nvseq_live.sv
module nvseq_live
  import nvseq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hiz_i,
  input  logic            load_all_i,
  input  bank_t           bank_i,
  input  logic            we_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic [DW-1:0]   data_i,
  output bank_t           live_o
);
  bank_t live_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        live_q[g] <= HIZ_VAL;
      else if (hiz_i)                     live_q[g] <= HIZ_VAL;
      else if (load_all_i)                live_q[g] <= bank_i[g];
      else if (we_i && (ch_i == CH_W'(g))) live_q[g] <= data_i;
    end
  end

  assign live_o = live_q;
endmodule

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
  import nvseq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int RECALL_CYCLES = 2000,
  parameter int COMMIT_CYCLES = 10000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             req_i,
  input  logic [CH_W-1:0]  req_ch_i,
  input  logic [DW-1:0]    req_data_i,
  input  logic             stop_i,
  input  logic             tmr_done_i,
  output logic             tmr_en_o,
  output logic             tmr_clr_o,
  output logic [CNT_W-1:0] tmr_limit_o,
  output logic             hiz_o,
  output logic             load_all_o,
  output logic             live_we_o,
  output logic             store_we_o,
  output logic [CH_W-1:0]  store_ch_o,
  output logic [DW-1:0]    store_data_o,
  output logic             busy_o,
  output logic             recall_done_o,
  output logic             standby_o
);
  seq_state_e      state_q, state_d;
  logic            armed_q;
  logic [CH_W-1:0] pend_ch_q;
  logic [DW-1:0]   pend_data_q;
  logic            done_q, stby_q;
  logic            accept, start_commit;

  assign busy_o       = (state_q != ST_IDLE);
  assign accept       = req_i && !busy_o && (req_ch_i < CH_W'(NUM_CH));
  assign start_commit = (state_q == ST_IDLE) && stop_i && armed_q;

  assign tmr_en_o    = busy_o && !soft_rst_i;
  assign tmr_clr_o   = soft_rst_i;
  assign tmr_limit_o = (state_q == ST_RECALL) ? CNT_W'(RECALL_CYCLES)
                                              : CNT_W'(COMMIT_CYCLES);

  assign hiz_o        = soft_rst_i;
  assign load_all_o   = (state_q == ST_RECALL) && tmr_done_i && !soft_rst_i;
  assign live_we_o    = accept && !soft_rst_i;
  assign store_we_o   = (state_q == ST_COMMIT) && tmr_done_i && !soft_rst_i;
  assign store_ch_o   = pend_ch_q;
  assign store_data_o = pend_data_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RECALL: if (tmr_done_i) state_d = ST_IDLE;
      ST_IDLE:   if (start_commit) state_d = ST_COMMIT;
      ST_COMMIT: if (tmr_done_i) state_d = ST_IDLE;
      default:   state_d = ST_RECALL;
    endcase
    if (soft_rst_i) state_d = ST_RECALL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_RECALL;
      armed_q     <= 1'b0;
      pend_ch_q   <= '0;
      pend_data_q <= '0;
      done_q      <= 1'b0;
      stby_q      <= 1'b0;
    end else if (soft_rst_i) begin
      state_q <= ST_RECALL;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      stby_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        armed_q     <= 1'b1;
        pend_ch_q   <= req_ch_i;
        pend_data_q <= req_data_i;
      end else if (store_we_o) begin
        armed_q <= 1'b0;
      end
      if (load_all_o) done_q <= 1'b1;
      // later events win: accept clears, completion or idle stop sets
      if (load_all_o || store_we_o)                        stby_q <= 1'b1;
      else if (start_commit || accept)                     stby_q <= 1'b0;
      else if ((state_q == ST_IDLE) && stop_i && !armed_q) stby_q <= 1'b1;
    end
  end

  assign recall_done_o = done_q;
  assign standby_o     = stby_q;

  // R5: a commit is entered only from idle on a stop with a byte armed
  p_commit_needs_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COMMIT && $past(state_q) == ST_IDLE) |-> $past(stop_i && armed_q));
  // R10: standby is never shown while busy
  p_no_standby_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && standby_o));
  // R2/R5: busy drops only when a timed window expires
  p_busy_fall_timed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(tmr_done_i));
  // R6: nothing is accepted while busy
  p_drop_when_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !live_we_o);
endmodule

// File: rtl/nvseq_top.sv
module nvseq_top
  import nvseq_pkg::*;
#(
  parameter int RECALL_CYCLES = 2000,
  parameter int COMMIT_CYCLES = 10000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       commit_req_i,
  input  logic [1:0] commit_ch_i,
  input  logic [7:0] commit_data_i,
  input  logic       stop_seen_i,
  output logic       busy_o,
  output logic       recall_done_o,
  output logic [7:0] live0_o,
  output logic [7:0] live1_o,
  output logic [7:0] live2_o,
  output logic       standby_o
);
  localparam int MAX_CYC = (RECALL_CYCLES > COMMIT_CYCLES) ? RECALL_CYCLES : COMMIT_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             tmr_en, tmr_clr, tmr_done;
  logic [CNT_W-1:0] tmr_limit;
  logic             hiz, load_all, live_we, store_we;
  logic [CH_W-1:0]  store_ch;
  logic [DW-1:0]    store_data;
  bank_t            bank, live;

  nvseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .clr_i(tmr_clr), .en_i(tmr_en), .limit_i(tmr_limit), .done_o(tmr_done)
  );

  nvseq_ctrl #(
    .CNT_W(CNT_W), .RECALL_CYCLES(RECALL_CYCLES), .COMMIT_CYCLES(COMMIT_CYCLES)
  ) u_ctrl (
    .clk_i, .rst_ni, .soft_rst_i,
    .req_i(commit_req_i), .req_ch_i(commit_ch_i), .req_data_i(commit_data_i),
    .stop_i(stop_seen_i), .tmr_done_i(tmr_done),
    .tmr_en_o(tmr_en), .tmr_clr_o(tmr_clr), .tmr_limit_o(tmr_limit),
    .hiz_o(hiz), .load_all_o(load_all), .live_we_o(live_we),
    .store_we_o(store_we), .store_ch_o(store_ch), .store_data_o(store_data),
    .busy_o, .recall_done_o, .standby_o
  );

  nvseq_store u_store (
    .clk_i, .rst_ni,
    .we_i(store_we), .ch_i(store_ch), .data_i(store_data), .bank_o(bank)
  );

  nvseq_live u_live (
    .clk_i, .rst_ni,
    .hiz_i(hiz), .load_all_i(load_all), .bank_i(bank),
    .we_i(live_we), .ch_i(commit_ch_i), .data_i(commit_data_i), .live_o(live)
  );

  assign live0_o = live[0];
  assign live1_o = live[1];
  assign live2_o = live[2];

  // R3: outputs stay high-impedance until recall has completed
  p_hiz_before_recall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !recall_done_o |-> (live0_o == HIZ_VAL && live1_o == HIZ_VAL && live2_o == HIZ_VAL));
  // R2: recall_done is only shown when not busy or during a later commit
  p_done_rises_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(recall_done_o) |-> !busy_o);
endmodule

// File: tb/nvseq_top_tb_top.sv
module nvseq_top_tb_top;
  localparam int RC = 12;
  localparam int CC = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic       commit_req_i = 1'b0;
  logic [1:0] commit_ch_i = '0;
  logic [7:0] commit_data_i = '0;
  logic       stop_seen_i = 1'b0;
  logic       busy_o, recall_done_o, standby_o;
  logic [7:0] live0_o, live1_o, live2_o;

  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;

  nvseq_top #(.RECALL_CYCLES(RC), .COMMIT_CYCLES(CC)) dut_i (
    .clk_i, .rst_ni, .soft_rst_i, .commit_req_i, .commit_ch_i, .commit_data_i,
    .stop_seen_i, .busy_o, .recall_done_o, .live0_o, .live1_o, .live2_o, .standby_o
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    for (int i = 0; i < 1000 && busy_o; i++) begin
      n++;
      tick();
    end
  endtask

  task automatic chk_lives(input string req, input int a, input int b, input int c);
    chk(req, live0_o, a);
    chk(req, live1_o, b);
    chk(req, live2_o, c);
  endtask

  task automatic write_ch(input logic [1:0] ch, input logic [7:0] d);
    commit_req_i = 1'b1; commit_ch_i = ch; commit_data_i = d;
    tick();
    commit_req_i = 1'b0;
  endtask

  task automatic stop_pulse();
    stop_seen_i = 1'b1;
    tick();
    stop_seen_i = 1'b0;
  endtask

  task automatic t_power_on();
    int n;
    @(negedge clk_i);
    chk("R3 hiz in reset", {live0_o, live1_o, live2_o}, 24'h808080);
    chk("R3 done low", recall_done_o, 0);
    chk("R10 standby low in reset", standby_o, 0);
    rst_ni = 1'b1;
    count_busy(n);
    chk("R2 recall length", n, RC);
    chk("R2 recall_done", recall_done_o, 1);
    chk_lives("R1 defaults", 8'h7F, 8'h7F, 8'h7F);
    chk("R10 standby after recall", standby_o, 1);
  endtask

  task automatic t_write_commit();
    int n;
    write_ch(2'd0, 8'h15);
    chk("R4 live0 updated", live0_o, 8'h15);
    chk("R10 standby cleared", standby_o, 0);
    tick(); tick();
    chk("R4 no commit before stop", busy_o, 0);
    stop_pulse();
    count_busy(n);
    chk("R5 commit length", n, CC);
    chk("R10 standby after commit", standby_o, 1);
  endtask

  task automatic t_drop_busy();
    int n;
    write_ch(2'd2, 8'h40);
    stop_pulse();
    chk("R5 busy after stop", busy_o, 1);
    tick(); tick();
    write_ch(2'd2, 8'h11);
    chk("R6 live2 held", live2_o, 8'h40);
    count_busy(n);
    stop_pulse();
    chk("R6 no commit from dropped", busy_o, 0);
    chk("R10 standby on idle stop", standby_o, 1);
  endtask

  task automatic t_bad_channel();
    write_ch(2'd3, 8'h99);
    chk_lives("R7 ch3 ignored", 8'h15, 8'h7F, 8'h40);
    chk("R7 standby kept", standby_o, 1);
    stop_pulse();
    chk("R7 nothing armed", busy_o, 0);
  endtask

  task automatic t_soft_reset();
    int n;
    write_ch(2'd1, 8'h05);
    chk("R4 live1 updated", live1_o, 8'h05);
    soft_rst_i = 1'b1;
    tick();
    soft_rst_i = 1'b0;
    chk_lives("R8 hiz after soft reset", 8'h80, 8'h80, 8'h80);
    chk("R8 done cleared", recall_done_o, 0);
    count_busy(n);
    chk("R8 recall length", n, RC);
    chk_lives("R8 store kept", 8'h15, 8'h7F, 8'h40);
  endtask

  task automatic t_last_wins();
    int n;
    write_ch(2'd0, 8'h22);
    write_ch(2'd1, 8'h33);
    stop_pulse();
    count_busy(n);
    chk("R5 commit length again", n, CC);
    soft_rst_i = 1'b1;
    tick();
    soft_rst_i = 1'b0;
    count_busy(n);
    chk_lives("R11 only last committed", 8'h15, 8'h33, 8'h40);
  endtask

  task automatic t_por_defaults();
    int n;
    rst_ni = 1'b0;
    tick();
    rst_ni = 1'b1;
    count_busy(n);
    chk("R2 recall after por", n, RC);
    chk_lives("R9 defaults restored", 8'h7F, 8'h7F, 8'h7F);
  endtask

  initial begin
    fork
      begin
        t_power_on();
        t_write_commit();
        t_drop_busy();
        t_bad_channel();
        t_soft_reset();
        t_last_wins();
        t_por_defaults();
      end
      begin
        repeat (20000) @(posedge clk_i);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule